// File: doc/BRIEF.md
# SPI Status and Error Flag Controller

This block holds the status side of a serial peripheral interface. It sits next to a shift engine and a CPU register port. From the shifter it takes a busy level, a byte-complete strobe with the received byte, and the slave-select input. From the CPU it takes single-cycle strobes for a status read, a data read, a data write and a control write. It keeps four flags: byte complete, write collision, overrun and mode fault. It also holds the control bits for enable, master and interrupt enable, and drives a single interrupt request.

Every flag except overrun is cleared by an ordered pair of register accesses. A status read made while the flag is set arms the flag, and the matching access that follows clears it. Overrun clears on the status read alone. A mode fault turns the peripheral off and returns it to slave mode. Until the fault is cleared, the enable and master bits cannot be set again, except by the control write that completes the clearing pair.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset all flags, the control bits, the interrupt output, the receive byte and the transmit byte read as zero.
- R2: If the master bit is set while slave-select is low at a clock edge, the mode-fault flag (status bit 4) is set and both the enable bit and the master bit are cleared at that same edge.
- R3: The mode-fault flag clears only through a control write that follows a status read made while the flag was set. A control write with no such earlier read leaves the flag set.
- R4: While the mode-fault flag is set, a control write cannot set the enable bit (control bit 0) or the master bit (control bit 1), although the interrupt-enable bit (control bit 2) is still written. The control write that completes the clearing pair applies all of its bits.
- R5: A byte-complete strobe sets the transfer-complete flag (status bit 7) and latches the received byte, provided the flag was clear.
- R6: A byte-complete strobe that arrives while the transfer-complete flag is set sets the overrun flag (status bit 5), and the received byte register keeps its earlier value.
- R7: A status read made while overrun is set clears overrun at the next edge.
- R8: A data write while the shifter is busy sets the write-collision flag (status bit 6), and the write is dropped: the transmit byte does not change and no load pulse is issued. A data write while the shifter is idle stores the byte and pulses the load output for one cycle.
- R9: A status read followed by a data read clears both transfer-complete and write-collision, each of them only if it was set at the time of the read. A data write in place of the data read clears neither.
- R10: A status read made while a flag is clear does not arm it. A data read after the flag sets, with no new status read, leaves the flag set.
- R11: The interrupt output equals interrupt enable ANDed with the OR of transfer-complete, overrun and mode fault. Write collision alone never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n_i | input | 1 | Slave-select input, low active |
| busy_i | input | 1 | Shifter has a byte in flight |
| byte_done_i | input | 1 | One-cycle strobe when a byte completes |
| rx_byte_i | input | DATA_W | Byte received by the shifter |
| st_rd_i | input | 1 | CPU status-register read strobe |
| dr_rd_i | input | 1 | CPU data-register read strobe |
| dr_wr_i | input | 1 | CPU data-register write strobe |
| dr_wdata_i | input | DATA_W | Data written by the CPU |
| ctl_wr_i | input | 1 | CPU control-register write strobe |
| ctl_wdata_i | input | 3 | Control write value: bit 2 interrupt enable, bit 1 master, bit 0 enable |
| status_o | output | DATA_W | Flag vector, bits 7..4 as above, others zero |
| rx_data_o | output | DATA_W | Held received byte |
| tx_data_o | output | DATA_W | Accepted transmit byte |
| tx_load_o | output | 1 | One-cycle pulse after an accepted data write |
| spi_en_o | output | 1 | Peripheral enable bit |
| master_o | output | 1 | Master mode bit |
| irq_en_o | output | 1 | Interrupt enable bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the mode-fault lock. It needs a control write made while the fault flag is set, when no status read has armed the flag yet. The stimulus sets master mode, pulls slave-select low for one cycle, and then writes all control bits before any status read. It confirms that only interrupt enable takes effect. A status read followed by a second control write then shows the completing write restoring the enable and master bits. A second hard case is an arming read that comes too early: a status read is issued before the byte completes, so the data read that follows must leave the flag set.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

   // status vector bit positions
   localparam int ST_DONE = 7;
   localparam int ST_WCOL = 6;
   localparam int ST_OVR  = 5;
   localparam int ST_MODF = 4;

   // control fields
   typedef struct packed {
      logic ie;
      logic mst;
      logic en;
   } ctl_t;

endpackage

// File: rtl/spi_seq_flag.sv
// One sticky flag with its clearing sequence. READ_CLEARS picks the
// variant: clear on a status read alone, or read-then-finish with an armed bit.
module spi_seq_flag #(
   parameter bit READ_CLEARS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic st_rd_i,
   input  logic finish_i,
   output logic flag_o,
   output logic armed_o,
   output logic clr_o
);

   logic flag_q;
   logic clr;

   generate
      if (READ_CLEARS) begin : g_rd
         assign clr     = st_rd_i & flag_q;
         assign armed_o = 1'b0;
      end else begin : g_seq
         logic armed_q;

         assign clr     = armed_q & finish_i & flag_q;
         assign armed_o = armed_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               armed_q <= 1'b0;
            else if (clr)
               armed_q <= 1'b0;
            else if (st_rd_i && flag_q)
               armed_q <= 1'b1;
            else if (!flag_q)
               armed_q <= 1'b0;
         end

         // R10: only a read while set arms, so the armed bit implies the flag
         a_r10_armed_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |-> flag_q);
         // R10: an arming read seen while the flag is clear does not arm
         a_r10_no_arm_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q && !armed_q && !set_i) |=> !armed_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign clr_o  = clr & ~set_i;

endmodule

// File: rtl/spi_ctl_reg.sv
// Control bits with the mode-fault override and lock.
module spi_ctl_reg
   import spi_flag_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fault_i,
   input  logic wr_i,
   input  ctl_t wdata_i,
   input  logic modf_i,
   input  logic unlock_i,
   output ctl_t ctl_o
);

   ctl_t ctl_q;
   logic locked;

   assign locked = modf_i & ~unlock_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (wr_i)
            ctl_q.ie <= wdata_i.ie;
         if (fault_i) begin
            ctl_q.en  <= 1'b0;
            ctl_q.mst <= 1'b0;
         end else if (wr_i) begin
            ctl_q.en  <= locked ? 1'b0 : wdata_i.en;
            ctl_q.mst <= locked ? 1'b0 : wdata_i.mst;
         end
      end
   end

   assign ctl_o = ctl_q;

   // R4: a locked write leaves enable and master low
   a_r4_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && modf_i && !unlock_i) |=> (!ctl_q.en && !ctl_q.mst));

endmodule

// File: rtl/spi_data_regs.sv
// Receive hold and transmit byte registers with collision detect.
module spi_data_regs #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done_i,
   input  logic          done_flag_i,
   input  logic [DW-1:0] rx_i,
   input  logic          busy_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rx_o,
   output logic [DW-1:0] tx_o,
   output logic          load_o,
   output logic          coll_o
);

   logic [DW-1:0] rx_q, tx_q;
   logic          load_q;
   logic          accept;

   assign accept = wr_i & ~busy_i;
   assign coll_o = wr_i & busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q   <= '0;
         tx_q   <= '0;
         load_q <= 1'b0;
      end else begin
         if (done_i && !done_flag_i)
            rx_q <= rx_i;
         if (accept)
            tx_q <= wdata_i;
         load_q <= accept;
      end
   end

   assign rx_o   = rx_q;
   assign tx_o   = tx_q;
   assign load_o = load_q;

   // R8: a colliding write is dropped
   a_r8_drop_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && busy_i) |=> (!load_q && $stable(tx_q)));

endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
   import spi_flag_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SS_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_n_i,
   input  logic              busy_i,
   input  logic              byte_done_i,
   input  logic [DATA_W-1:0] rx_byte_i,
   input  logic              st_rd_i,
   input  logic              dr_rd_i,
   input  logic              dr_wr_i,
   input  logic [DATA_W-1:0] dr_wdata_i,
   input  logic              ctl_wr_i,
   input  logic [2:0]        ctl_wdata_i,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_load_o,
   output logic              spi_en_o,
   output logic              master_o,
   output logic              irq_en_o,
   output logic              irq_o
);

   localparam int SYNC_W = (SS_SYNC > 0) ? SS_SYNC : 1;

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must hold the status bits");
      assert (SS_SYNC >= 0 && SS_SYNC <= 4) else $error("SS_SYNC out of range");
   end

   logic ss_n;
   ctl_t ctl;
   logic fault;
   logic done_q, ovr_q, wcol_q, modf_q;
   logic modf_clr;
   logic coll;
   logic done_arm, wcol_arm, ovr_arm, modf_arm;
   logic done_clr, wcol_clr, ovr_clr;

   generate
      if (SS_SYNC > 0) begin : g_sync
         logic [SYNC_W-1:0] ss_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ss_pipe <= '1;
            else
               ss_pipe <= {ss_pipe[SYNC_W-2+1-1:0], ss_n_i} >> 0;
         end
         assign ss_n = ss_pipe[SYNC_W-1];
      end else begin : g_direct
         assign ss_n = ss_n_i;
      end
   endgenerate

   assign fault = ctl.mst & ~ss_n;

   spi_ctl_reg u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .fault_i (fault),
      .wr_i    (ctl_wr_i),
      .wdata_i (ctl_t'(ctl_wdata_i)),
      .modf_i  (modf_q),
      .unlock_i(modf_clr),
      .ctl_o   (ctl)
   );

   spi_data_regs #(.DW(DATA_W)) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (byte_done_i),
      .done_flag_i(done_q),
      .rx_i       (rx_byte_i),
      .busy_i     (busy_i),
      .wr_i       (dr_wr_i),
      .wdata_i    (dr_wdata_i),
      .rx_o       (rx_data_o),
      .tx_o       (tx_data_o),
      .load_o     (tx_load_o),
      .coll_o     (coll)
   );

   spi_seq_flag #(.READ_CLEARS(1'b0)) u_done (
      .clk(clk), .rst_n(rst_n), .set_i(byte_done_i), .st_rd_i(st_rd_i),
      .finish_i(dr_rd_i), .flag_o(done_q), .armed_o(done_arm), .clr_o(done_clr)
   );

   spi_seq_flag #(.READ_CLEARS(1'b0)) u_wcol (
      .clk(clk), .rst_n(rst_n), .set_i(coll), .st_rd_i(st_rd_i),
      .finish_i(dr_rd_i), .flag_o(wcol_q), .armed_o(wcol_arm), .clr_o(wcol_clr)
   );

   spi_seq_flag #(.READ_CLEARS(1'b1)) u_ovr (
      .clk(clk), .rst_n(rst_n), .set_i(byte_done_i & done_q), .st_rd_i(st_rd_i),
      .finish_i(1'b0), .flag_o(ovr_q), .armed_o(ovr_arm), .clr_o(ovr_clr)
   );

   spi_seq_flag #(.READ_CLEARS(1'b0)) u_modf (
      .clk(clk), .rst_n(rst_n), .set_i(fault), .st_rd_i(st_rd_i),
      .finish_i(ctl_wr_i), .flag_o(modf_q), .armed_o(modf_arm), .clr_o(modf_clr)
   );

   always_comb begin
      status_o          = '0;
      status_o[ST_DONE] = done_q;
      status_o[ST_WCOL] = wcol_q;
      status_o[ST_OVR]  = ovr_q;
      status_o[ST_MODF] = modf_q;
   end

   assign spi_en_o = ctl.en;
   assign master_o = ctl.mst;
   assign irq_en_o = ctl.ie;
   assign irq_o    = ctl.ie & (done_q | ovr_q | modf_q);

   // R2: a fault drops enable and master and raises the flag
   a_r2_fault_drops_mode: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (modf_q && !ctl.en && !ctl.mst));
   // R4: enable and master stay low while the fault flag is up
   a_r4_locked_while_fault: assert property (@(posedge clk) disable iff (!rst_n)
      modf_q |-> (!ctl.en && !ctl.mst));
   // R6: a second byte before the flag clears sets overrun and keeps the byte
   a_r6_keep_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done_i && done_q) |=> (ovr_q && $stable(rx_data_o)));
   // R7: status read clears overrun unless a new overrun arrives
   a_r7_ovr_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && st_rd_i && !(byte_done_i && done_q)) |=> !ovr_q);
   // R11: collision alone never interrupts
   a_r11_wcol_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_q && !ovr_q && !modf_q) |-> !irq_o);

endmodule

// File: tb/test_spi_flag_ctrl.sv
module test_spi_flag_ctrl;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ss_n = 1'b1, busy = 1'b0, bdone = 1'b0;
   logic [W-1:0] rxb = '0, dwd = '0;
   logic         st_rd = 1'b0, dr_rd = 1'b0, dr_wr = 1'b0, ctl_wr = 1'b0;
   logic [2:0]   cwd = '0;
   logic [W-1:0] status, rxd, txd;
   logic         tx_load, en, mst, ie, irq;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   spi_flag_ctrl #(.DATA_W(W)) i_spi_flag_ctrl (
      .clk(clk), .rst_n(rst_n), .ss_n_i(ss_n), .busy_i(busy),
      .byte_done_i(bdone), .rx_byte_i(rxb), .st_rd_i(st_rd), .dr_rd_i(dr_rd),
      .dr_wr_i(dr_wr), .dr_wdata_i(dwd), .ctl_wr_i(ctl_wr), .ctl_wdata_i(cwd),
      .status_o(status), .rx_data_o(rxd), .tx_data_o(txd), .tx_load_o(tx_load),
      .spi_en_o(en), .master_o(mst), .irq_en_o(ie), .irq_o(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // each access: assert at a falling edge, release at the next one
   task automatic do_st_rd();
      @(negedge clk); st_rd = 1'b1; @(negedge clk); st_rd = 1'b0;
   endtask
   task automatic do_dr_rd();
      @(negedge clk); dr_rd = 1'b1; @(negedge clk); dr_rd = 1'b0;
   endtask
   task automatic do_dr_wr(input logic [W-1:0] v);
      @(negedge clk); dwd = v; dr_wr = 1'b1; @(negedge clk); dr_wr = 1'b0;
   endtask
   task automatic do_ctl_wr(input logic [2:0] v);
      @(negedge clk); cwd = v; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0;
   endtask
   task automatic do_byte(input logic [W-1:0] v);
      @(negedge clk); rxb = v; bdone = 1'b1; @(negedge clk); bdone = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 status", status, 0);
      check("R1 ctl", {en, mst, ie}, 0);
      check("R1 irq", irq, 0);
      check("R1 rx/tx", {rxd, txd}, 0);
   endtask

   task automatic t_capture();
      do_byte(8'hA5);
      check("R5 done bit7", status, 8'h80);
      check("R5 rx byte", rxd, 8'hA5);
      check("R11 irq off when ie=0", irq, 0);
      do_ctl_wr(3'b100);
      check("R11 irq on done", irq, 1);
      do_st_rd();
      do_dr_rd();
      check("R9 done cleared", status, 0);
      check("R11 irq drops", irq, 0);
   endtask

   task automatic t_overrun();
      do_byte(8'h11);
      do_byte(8'h22);
      check("R6 ovr set", status, 8'hA0);
      check("R6 rx keeps first", rxd, 8'h11);
      check("R11 irq ovr", irq, 1);
      do_st_rd();
      check("R7 ovr cleared", status, 8'h80);
      do_dr_rd();
      check("R9 done cleared after ovr", status, 0);
      do_byte(8'h33);
      check("R5 new byte latched", rxd, 8'h33);
      do_st_rd();
      do_dr_rd();
   endtask

   task automatic t_collision();
      do_dr_wr(8'h5A);
      check("R8 idle write loads", txd, 8'h5A);
      check("R8 load pulse", tx_load, 1);
      @(negedge clk); busy = 1'b1;
      do_dr_wr(8'hC3);
      check("R8 wcol bit6", status, 8'h40);
      check("R8 tx unchanged", txd, 8'h5A);
      check("R8 no load pulse", tx_load, 0);
      check("R11 wcol no irq", irq, 0);
      busy = 1'b0;
      do_st_rd();
      do_dr_wr(8'h77);
      check("R9 data write keeps wcol", status, 8'h40);
      check("R8 idle write after", txd, 8'h77);
      do_dr_rd();
      check("R9 wcol cleared", status, 0);
   endtask

   task automatic t_no_arm();
      do_st_rd();
      do_byte(8'h44);
      do_dr_rd();
      check("R10 early read no arm", status, 8'h80);
      do_st_rd();
      do_dr_rd();
      check("R10 proper sequence clears", status, 0);
   endtask

   task automatic t_modf();
      do_ctl_wr(3'b011);
      check("R4 normal write", {ie, mst, en}, 3'b011);
      @(negedge clk); ss_n = 1'b0;
      @(negedge clk); ss_n = 1'b1;
      check("R2 modf bit4", status, 8'h10);
      check("R2 en/mst dropped", {mst, en}, 2'b00);
      check("R11 irq off ie=0", irq, 0);
      do_ctl_wr(3'b111);
      check("R3 unarmed write keeps modf", status, 8'h10);
      check("R4 lock keeps en/mst low, ie written", {ie, mst, en}, 3'b100);
      check("R11 irq on modf", irq, 1);
      do_st_rd();
      check("R3 read alone keeps modf", status, 8'h10);
      do_ctl_wr(3'b011);
      check("R3 modf cleared", status, 0);
      check("R4 completing write applies", {ie, mst, en}, 3'b011);
      check("R11 irq off", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_capture();
      t_overrun();
      t_collision();
      t_no_arm();
      t_modf();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule